// File: doc/BRIEF.md
# Host receive-status queue with peek and pop read port

This block holds the status words that a full-speed USB host packet engine produces as IN traffic arrives on its channels. Each time the engine sees a receive event, it pushes one entry. An entry holds the channel number, the byte count, the data PID and a packet status code. The entries wait in a small first-in first-out store until software reads them.

Software reaches the head entry through two word addresses on a simple read port. One address peeks: it returns the head entry and leaves it in place. The other address pops: it returns the head entry and then drops it. A non-empty flag tells software when an entry is waiting. When software pops an entry whose status code signals completion, a data toggle error or a halted channel, the block emits a one-cycle event pulse. An interrupt controller can collect that pulse. If the packet engine pushes into a full queue, the entry is discarded and a sticky overflow bit is set.

Top module: `usbh_rxstat_queue`

## Requirements
- R1: After a synchronous reset, `rd_data` is zero and `fifo_nonempty`, `overflow` and `evt_pulse` are all low.
- R2: A read that returns an entry drives it on `rd_data` in the cycle after the request, with this layout:
  - bits 3:0 hold the channel number;
  - bits 14:4 hold the byte count;
  - bits 16:15 hold the data PID, where 00 means DATA0;
  - bits 20:17 hold the packet status;
  - bits 31:21 read as zero.
- R3: A 32-bit read at byte offset 0x1C returns the head entry and does not remove it, so repeated peeks return the same word.
- R4: A 32-bit read at byte offset 0x20 returns the head entry and removes it. Entries come out in the order they were pushed.
- R5: `fifo_nonempty` is high exactly when at least one entry is stored. It reflects a push or a pop from the cycle after that clock edge.
- R6: `evt_pulse` goes high for exactly one cycle, the same cycle that shows the popped word, when the popped status is 0011 (IN transfer completed), 0101 (data toggle error) or 0111 (channel halted). Popping status 0010 (IN data received) or any other code raises no event, and a peek never raises one.
- R7: A read of either address while the queue is empty returns zero, moves no pointer and raises no event.
- R8: A read with `rd_word` low (narrower than 32 bits) returns zero and does not pop.
- R9: A push and a pop in the same cycle are both honoured, so the occupancy stays the same.
- R10: A push while the queue holds DEPTH entries is dropped, even if a pop happens in the same cycle. The drop sets `overflow`, which then stays high until reset.
- R11: A read at any offset other than 0x1C or 0x20 returns zero and does not pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Packet engine pushes one entry this cycle |
| push_chnum | input | 4 | Channel number of the pushed entry |
| push_bcount | input | 11 | Byte count of the pushed entry |
| push_dpid | input | 2 | Data PID of the pushed entry |
| push_pktst | input | 4 | Packet status of the pushed entry |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_word | input | 1 | High for a full 32-bit access |
| rd_data | output | 32 | Read result, valid in the cycle after the request |
| fifo_nonempty | output | 1 | At least one entry is stored |
| overflow | output | 1 | Sticky: a push was dropped because the queue was full |
| evt_pulse | output | 1 | One-cycle event on popping an event-class status |

## Verification
The hardest case to reach is a push that arrives while the queue is full and a pop happens in the same cycle. The push must still be dropped, the occupancy must fall by one and `overflow` must stay set. The bench reaches this case by filling the queue to its limit and then driving a push together with a pop at offset 0x20. A reference queue in the bench predicts every returned word and event.

The bench also pushes all sixteen status codes in two full batches, so that each code is popped once and the event decision is checked against every encoding. Reads that are empty, narrower than 32 bits or at a stray offset are each followed by a peek. That peek shows at the port whether the head entry moved.

// File: rtl/usbh_rxstat_pkg.sv
package usbh_rxstat_pkg;

  localparam int CHN_W = 4;
  localparam int BCNT_W = 11;
  localparam int PID_W = 2;
  localparam int STS_W = 4;
  localparam int ENTRY_W = STS_W + PID_W + BCNT_W + CHN_W;

  // Field order follows the bit positions software decodes.
  typedef struct packed {
    logic [STS_W-1:0]  pktst;
    logic [PID_W-1:0]  dpid;
    logic [BCNT_W-1:0] bcount;
    logic [CHN_W-1:0]  chnum;
  } rx_entry_t;

  localparam logic [STS_W-1:0] STS_IN_DATA  = 4'b0010;
  localparam logic [STS_W-1:0] STS_IN_DONE  = 4'b0011;
  localparam logic [STS_W-1:0] STS_TOG_ERR  = 4'b0101;
  localparam logic [STS_W-1:0] STS_CH_HALT  = 4'b0111;

  function automatic logic sts_is_event(input logic [STS_W-1:0] s);
    return (s == STS_IN_DONE) || (s == STS_TOG_ERR) || (s == STS_CH_HALT);
  endfunction

endpackage

// File: rtl/usbh_rxstat_mem.sv
module usbh_rxstat_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 21,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] store [DEPTH];

  // Write-only clocked process with no reset, so distributed RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  assign rd_data = store[rd_ptr];

endmodule

// File: rtl/usbh_rxstat_ctrl.sv
module usbh_rxstat_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic full;
  logic do_pop;

  assign full   = (count == FULL_CNT);
  assign wr_en  = push_req && !full;
  assign do_pop = pop_req && (count != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en)  wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      case ({wr_en, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_req && full) overflow <= 1'b1;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_both_keep_count_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && do_pop) |=> $stable(count));

endmodule

// File: rtl/usbh_rxstat_rdport.sv
module usbh_rxstat_rdport
  import usbh_rxstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PEEK_OFS = 8'h1C,
  parameter logic [ADDR_W-1:0] POP_OFS  = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_word,
  input  logic              nonempty,
  input  rx_entry_t         head,
  output logic              pop_req,
  output logic [31:0]       rd_data,
  output logic              evt_pulse
);

  logic hit_peek, hit_pop, take;

  assign hit_peek = rd_en && rd_word && (rd_addr == PEEK_OFS);
  assign hit_pop  = rd_en && rd_word && (rd_addr == POP_OFS);
  assign take     = (hit_peek || hit_pop) && nonempty;
  assign pop_req  = hit_pop && nonempty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      evt_pulse <= 1'b0;
    end else begin
      rd_data   <= take ? {{(32-ENTRY_W){1'b0}}, head} : '0;
      evt_pulse <= pop_req && sts_is_event(head.pktst);
    end
  end

  assert_evt_single_R6: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |=> !evt_pulse || $past(pop_req));

endmodule

// File: rtl/usbh_rxstat_queue.sv
module usbh_rxstat_queue
  import usbh_rxstat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ADDR_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [3:0]        push_chnum,
  input  logic [10:0]       push_bcount,
  input  logic [1:0]        push_dpid,
  input  logic [3:0]        push_pktst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_word,
  output logic [31:0]       rd_data,
  output logic              fifo_nonempty,
  output logic              overflow,
  output logic              evt_pulse
);

  rx_entry_t        wr_entry, head;
  logic             wr_en, pop_req;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign wr_entry = '{pktst: push_pktst, dpid: push_dpid,
                      bcount: push_bcount, chnum: push_chnum};
  assign fifo_nonempty = (count != '0);

  usbh_rxstat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(push_valid), .pop_req(pop_req),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .overflow(overflow)
  );

  usbh_rxstat_mem #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_entry),
    .rd_ptr(rd_ptr), .rd_data(head)
  );

  usbh_rxstat_rdport #(.ADDR_W(ADDR_W)) u_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_word(rd_word),
    .nonempty(fifo_nonempty), .head(head), .pop_req(pop_req),
    .rd_data(rd_data), .evt_pulse(evt_pulse)
  );

  assert_empty_read_still_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !fifo_nonempty) |=> $stable(rd_ptr));

  assert_evt_from_pop_R6: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |-> (rd_ptr != $past(rd_ptr)) || (DEPTH == 1));

  assert_narrow_no_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_word) |=> $stable(rd_ptr));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data != '0) |-> $past(rd_en && fifo_nonempty));

endmodule

// File: tb/usbh_rxstat_queue_bench.sv
`timescale 1ns/1ps
module usbh_rxstat_queue_bench;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        push_valid;
  logic [3:0]  push_chnum;
  logic [10:0] push_bcount;
  logic [1:0]  push_dpid;
  logic [3:0]  push_pktst;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic        rd_word;
  logic [31:0] rd_data;
  logic        fifo_nonempty, overflow, evt_pulse;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] mq[$];
  logic ovf_m = 1'b0;

  always #2.5 clk = ~clk;

  usbh_rxstat_queue u_usbh_rxstat_queue (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_chnum(push_chnum),
    .push_bcount(push_bcount), .push_dpid(push_dpid), .push_pktst(push_pktst),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_word(rd_word), .rd_data(rd_data),
    .fifo_nonempty(fifo_nonempty), .overflow(overflow), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int i, input logic [3:0] st);
    logic [3:0]  c = 4'(i % 16);
    logic [10:0] b = 11'((i * 97 + 3) % 2048);
    logic [1:0]  p = 2'(i % 4);
    return {11'b0, st, p, b, c};
  endfunction

  // One cycle: drive at negedge, sample at the next negedge, compare with model.
  task automatic step(input string tag, input logic pv, input logic [31:0] w,
                      input logic re, input logic [7:0] a, input logic wd);
    logic [31:0] exp_d;
    logic exp_e, hit, popit, do_push;
    push_valid = pv; push_chnum = w[3:0]; push_bcount = w[14:4];
    push_dpid = w[16:15]; push_pktst = w[20:17];
    rd_en = re; rd_addr = a; rd_word = wd;
    hit   = re && wd && (a == 8'h1C || a == 8'h20) && (mq.size() > 0);
    popit = hit && (a == 8'h20);
    exp_d = hit ? mq[0] : 32'h0;
    exp_e = popit && (mq[0][20:17] == 4'b0011 || mq[0][20:17] == 4'b0101 ||
                      mq[0][20:17] == 4'b0111);
    do_push = pv && (mq.size() < DEPTH);
    if (pv && !do_push) ovf_m = 1'b1;
    if (popit) void'(mq.pop_front());
    if (do_push) mq.push_back(w);
    @(negedge clk);
    push_valid = 1'b0; rd_en = 1'b0;
    chk(tag, "rd_data", rd_data, exp_d);
    chk(tag, "evt_pulse", 32'(evt_pulse), 32'(exp_e));
    chk(tag, "fifo_nonempty", 32'(fifo_nonempty), 32'(mq.size() > 0));
    chk(tag, "overflow", 32'(overflow), 32'(ovf_m));
  endtask

  initial begin
    #(5.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; push_valid = 0; rd_en = 0; rd_addr = 0; rd_word = 0;
    push_chnum = 0; push_bcount = 0; push_dpid = 0; push_pktst = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "nonempty", 32'(fifo_nonempty), 0);
    chk("R1", "overflow", 32'(overflow), 0);
    chk("R1", "evt", 32'(evt_pulse), 0);

    // R7 empty reads at both offsets
    step("R7", 0, 0, 1, 8'h1C, 1);
    step("R7", 0, 0, 1, 8'h20, 1);

    // R2 R3 R4 R5 R6: all 16 status codes, two full batches
    for (int bt = 0; bt < 2; bt++) begin
      for (int k = 0; k < DEPTH; k++) step("R5", 1, mk(bt*8 + k, 4'(bt*8 + k)), 0, 0, 1);
      step("R3", 0, 0, 1, 8'h1C, 1);
      step("R3", 0, 0, 1, 8'h1C, 1);
      for (int k = 0; k < DEPTH; k++) step("R6", 0, 0, 1, 8'h20, 1);
      step("R4", 0, 0, 1, 8'h20, 1);
    end

    // R7: after empty reads a push is the new head
    step("R7", 1, mk(40, 4'b0111), 0, 0, 1);
    step("R2", 0, 0, 1, 8'h1C, 1);

    // R8 narrow reads, R11 stray offsets, each followed by a peek
    step("R8", 0, 0, 1, 8'h20, 0);
    step("R8", 0, 0, 1, 8'h1C, 0);
    step("R8", 0, 0, 1, 8'h1C, 1);
    for (int a = 0; a < 64; a += 4)
      if (a != 8'h1C && a != 8'h20) step("R11", 0, 0, 1, 8'(a), 1);
    step("R11", 0, 0, 1, 8'h1C, 1);

    // R9 push and pop together at mid occupancy
    step("R9", 1, mk(41, 4'b0011), 0, 0, 1);
    for (int k = 0; k < 5; k++) step("R9", 1, mk(50 + k, 4'(k)), 1, 8'h20, 1);

    // R10 fill, overflow, full push with pop
    while (mq.size() < DEPTH) step("R10", 1, mk(60 + mq.size(), 4'b0010), 0, 0, 1);
    step("R10", 1, mk(70, 4'b0101), 0, 0, 1);
    step("R10", 1, mk(71, 4'b0101), 1, 8'h20, 1);
    while (mq.size() > 0) step("R10", 0, 0, 1, 8'h20, 1);
    step("R10", 0, 0, 1, 8'h1C, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule